// File: doc/BRIEF.md
# Multi-Drive Ready-Line Poller

This block watches the ready status of up to four disk drives through one shared ready input while the controller is idle. It drives the drive-select lines through each drive number in turn, keeps each selection for a fixed dwell time, and samples the shared ready line at the end of that dwell. It keeps one remembered ready bit per drive. When a sample differs from the remembered bit, the block marks that drive as having a pending change and raises an interrupt.

Polling stays off after reset. It starts when the controller reports that its timing-setup command has completed. It keeps running between commands and during commands that do not move data, such as head stepping. It freezes while a read or write command is active. A later interrupt-status query reads the lowest-numbered pending drive and its not-ready bit, then acknowledges it. The acknowledge clears that drive's flag. The interrupt drops once no drive has a change left to report.

Top module: `drive_ready_poller`

## Requirements
- R1: After reset, `unit_sel` is 0 and `int_o` is low. No sampling or stepping takes place until a one-cycle `specify_done` pulse arrives, whatever `ready_in` does.
- R2: Once enabled, `unit_sel` (the drive number in binary) steps through 0, 1, 2, 3 and back to 0. Each value is held for DWELL = POLL_PERIOD_CLKS / NUM_DRIVES clocks, counted from the clock edge that takes the `specify_done` pulse.
- R3: The ready line is sampled on the last clock of each dwell. The remembered state of every drive is "not ready" after reset, so a drive that is ready produces a change on its first visit.
- R4: A sample that differs from the drive's remembered bit sets that drive's pending flag. `int_o` is high in the cycle right after the sampling edge.
- R5: A sample that equals the remembered bit produces no interrupt.
- R6: While `cmd_busy` and `rw_active` are both high, `unit_sel` and the dwell count are frozen and no sampling occurs. Polling resumes from the same point afterwards.
- R7: Polling keeps running while only one of `cmd_busy` or `rw_active` is high.
- R8: `pend_drive` shows the lowest-numbered drive with a pending change. `pend_not_ready` is 1 when that drive's latest sampled state is not ready (`ready_in` was 0).
- R9: A `sense_ack` pulse while `int_o` is high clears the flag of the drive shown on `pend_drive`. The next lowest pending drive then appears.
- R10: `int_o` stays high while any flag is set and falls after the last flag is acknowledged.
- R11: A second change on a drive that is already pending leaves one pending entry, and `pend_not_ready` follows the newest sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| specify_done | input | 1 | One-cycle pulse: timing-setup command completed, enables polling |
| cmd_busy | input | 1 | A command is in progress |
| rw_active | input | 1 | The running command transfers data (read/write) |
| ready_in | input | 1 | Shared ready line of the selected drive |
| sense_ack | input | 1 | Interrupt-status query consumed the reported drive |
| unit_sel | output | 2 | Drive number currently selected |
| int_o | output | 1 | Interrupt: at least one drive has a pending ready change |
| pend_drive | output | 2 | Lowest-numbered drive with a pending change |
| pend_not_ready | output | 1 | Not-ready bit for `pend_drive` |

## Verification
The bench counts the exact dwell of every select value after enabling. A sampler that is off by one cycle, or that starts before the setup command, shows up as a wrong count or as early interrupts. It freezes polling in the middle of a dwell while a ready line changes; a design that ignores the freeze reports the change too early or moves the select lines. It sets changes on several drives and checks that they are reported from the lowest number up and that the interrupt drops only after the final acknowledge. A design that clears everything at once, or reports from the highest number down, fails these checks. Flipping an already-pending drive back checks that the status bit follows the newest sample and that no duplicate entry is left behind.

// File: rtl/poller_pkg.sv
package poller_pkg;
  // Index of the lowest set bit among the first n bits; 0 if none.
  function automatic int unsigned lowest_set(input logic [31:0] v, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(n) && v[i]) r = i;
    end
    return r;
  endfunction

  // Next drive number with wrap-around.
  function automatic int unsigned next_drive(input int unsigned d, input int unsigned n);
    return (d + 1 >= n) ? 0 : d + 1;
  endfunction
endpackage

// File: rtl/poll_sequencer.sv
module poll_sequencer #(
  parameter int NUM_DRIVES = 4,
  parameter int DWELL_CLKS = 2048,
  localparam int SEL_W = $clog2(NUM_DRIVES),
  localparam int CNT_W = $clog2(DWELL_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             specify_done,
  input  logic             hold,
  output logic [SEL_W-1:0] unit_sel,
  output logic             poll_en,
  output logic             sample_stb
);
  import poller_pkg::*;

  logic [CNT_W-1:0] dwell_cnt;
  logic             last_clk;

  assign last_clk   = (dwell_cnt == CNT_W'(DWELL_CLKS - 1));
  assign sample_stb = poll_en && !hold && last_clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poll_en   <= 1'b0;
      dwell_cnt <= '0;
      unit_sel  <= '0;
    end else begin
      if (specify_done) poll_en <= 1'b1;
      if (poll_en && !hold) begin
        if (last_clk) begin
          dwell_cnt <= '0;
          unit_sel  <= SEL_W'(next_drive(int'(unit_sel), NUM_DRIVES));
        end else begin
          dwell_cnt <= dwell_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ready_tracker.sv
module ready_tracker #(
  parameter int NUM_DRIVES = 4,
  localparam int SEL_W = $clog2(NUM_DRIVES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic [SEL_W-1:0] unit_sel,
  input  logic             ready_in,
  input  logic             sense_ack,
  output logic             int_o,
  output logic [SEL_W-1:0] pend_drive,
  output logic             pend_not_ready
);
  import poller_pkg::*;

  logic [NUM_DRIVES-1:0] rdy_mem;
  logic [NUM_DRIVES-1:0] pending;
  logic                  ack_hit;

  assign int_o          = |pending;
  assign ack_hit        = sense_ack && int_o;
  assign pend_drive     = SEL_W'(lowest_set(32'(pending), NUM_DRIVES));
  assign pend_not_ready = !rdy_mem[pend_drive];

  for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drive
    logic visit, change;
    assign visit  = sample_stb && (unit_sel == SEL_W'(i));
    assign change = visit && (ready_in != rdy_mem[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdy_mem[i] <= 1'b0;
        pending[i] <= 1'b0;
      end else begin
        if (visit) rdy_mem[i] <= ready_in;
        if (change) pending[i] <= 1'b1;
        else if (ack_hit && pend_drive == SEL_W'(i)) pending[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/drive_ready_poller.sv
module drive_ready_poller #(
  parameter int NUM_DRIVES       = 4,
  parameter int POLL_PERIOD_CLKS = 8192,
  localparam int SEL_W      = $clog2(NUM_DRIVES),
  localparam int DWELL_CLKS = POLL_PERIOD_CLKS / NUM_DRIVES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             specify_done,
  input  logic             cmd_busy,
  input  logic             rw_active,
  input  logic             ready_in,
  input  logic             sense_ack,
  output logic [SEL_W-1:0] unit_sel,
  output logic             int_o,
  output logic [SEL_W-1:0] pend_drive,
  output logic             pend_not_ready
);
  logic hold, poll_en, sample_stb;

  assign hold = cmd_busy && rw_active;

  poll_sequencer #(.NUM_DRIVES(NUM_DRIVES), .DWELL_CLKS(DWELL_CLKS)) i_seq (
    .clk(clk), .rst_n(rst_n), .specify_done(specify_done), .hold(hold),
    .unit_sel(unit_sel), .poll_en(poll_en), .sample_stb(sample_stb)
  );

  ready_tracker #(.NUM_DRIVES(NUM_DRIVES)) i_trk (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .unit_sel(unit_sel),
    .ready_in(ready_in), .sense_ack(sense_ack), .int_o(int_o),
    .pend_drive(pend_drive), .pend_not_ready(pend_not_ready)
  );
endmodule

// File: rtl/poller_checker.sv
module poller_checker #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_busy,
  input logic             rw_active,
  input logic             sense_ack,
  input logic             poll_en,
  input logic             sample_stb,
  input logic             int_o,
  input logic [SEL_W-1:0] unit_sel
);
  // R1
  idle_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_en |-> (unit_sel == '0 && !int_o));
  // R6
  frozen_no_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && rw_active) |-> !sample_stb);
  // R2
  select_moves_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(unit_sel) |-> $past(sample_stb));
  // R4
  int_rise_from_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_o) |-> $past(sample_stb));
  // R10
  int_fall_from_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_o) |-> $past(sense_ack));
endmodule

bind drive_ready_poller poller_checker #(.SEL_W(SEL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_busy(cmd_busy), .rw_active(rw_active),
  .sense_ack(sense_ack), .poll_en(poll_en), .sample_stb(sample_stb),
  .int_o(int_o), .unit_sel(unit_sel)
);

// File: tb/test_drive_ready_poller.sv
module test_drive_ready_poller;
  localparam int PERIOD = 64;
  localparam int DWELL  = PERIOD / 4;
  localparam int SWEEP  = PERIOD + 4;

  logic clk = 0, rst_n = 0;
  logic specify_done = 0, cmd_busy = 0, rw_active = 0, sense_ack = 0;
  logic [3:0] drv_rdy = '0;
  logic [1:0] unit_sel, pend_drive;
  logic int_o, pend_not_ready, ready_in;
  int checks = 0, errors = 0;

  assign ready_in = drv_rdy[unit_sel];

  always #10 clk = ~clk;

  drive_ready_poller #(.NUM_DRIVES(4), .POLL_PERIOD_CLKS(PERIOD)) i_drive_ready_poller (
    .clk(clk), .rst_n(rst_n), .specify_done(specify_done), .cmd_busy(cmd_busy),
    .rw_active(rw_active), .ready_in(ready_in), .sense_ack(sense_ack),
    .unit_sel(unit_sel), .int_o(int_o), .pend_drive(pend_drive),
    .pend_not_ready(pend_not_ready)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack();
    sense_ack = 1; @(negedge clk); sense_ack = 0;
  endtask

  task automatic t_reset();
    drv_rdy = 4'hF;
    wait_clks(3); rst_n = 1;
    check("R1 sel after reset", unit_sel, 0);
    check("R1 int after reset", int_o, 0);
    wait_clks(3 * PERIOD);
    check("R1 sel without specify", unit_sel, 0);
    check("R1 int without specify", int_o, 0);
  endtask

  task automatic t_sequence();
    int n;
    specify_done = 1; @(negedge clk); specify_done = 0;
    for (int d = 0; d < 4; d++) begin
      n = 0;
      while (unit_sel == 2'(d) && n < 1000) begin n++; @(negedge clk); end
      check($sformatf("R2 dwell of drive %0d", d), n, DWELL);
      check("R2 next drive", unit_sel, (d + 1) % 4);
      if (d == 0) begin
        check("R3 R4 int after first visit of ready drive", int_o, 1);
        check("R4 pending drive 0", pend_drive, 0);
      end
    end
    check("R8 lowest pending is 0", pend_drive, 0);
    check("R8 ready drive not-ready bit", pend_not_ready, 0);
    for (int d = 0; d < 4; d++) begin
      check("R9 report order", pend_drive, d);
      check("R10 int held until last ack", int_o, 1);
      ack();
    end
    check("R10 int falls after last ack", int_o, 0);
  endtask

  task automatic t_no_change();
    wait_clks(2 * SWEEP);
    check("R5 no interrupt without change", int_o, 0);
  endtask

  task automatic t_multi();
    drv_rdy[3] = 0; drv_rdy[1] = 0;
    wait_clks(SWEEP);
    check("R8 lowest of 1 and 3", pend_drive, 1);
    check("R8 not-ready bit", pend_not_ready, 1);
    ack();
    check("R9 next pending", pend_drive, 3);
    check("R10 int still high", int_o, 1);
    ack();
    check("R10 int low", int_o, 0);
  endtask

  task automatic t_pause();
    int guard = 0;
    while (unit_sel != 2'd1 && guard < 1000) begin guard++; @(negedge clk); end
    cmd_busy = 1; rw_active = 1;
    drv_rdy[3] = 1;
    wait_clks(5 * PERIOD);
    check("R6 select frozen", unit_sel, 1);
    check("R6 no sampling while frozen", int_o, 0);
    cmd_busy = 0; rw_active = 0;
    wait_clks(SWEEP);
    check("R6 change seen after resume", int_o, 1);
    check("R6 pending drive 3", pend_drive, 3);
    check("R6 ready bit for drive 3", pend_not_ready, 0);
    ack();
  endtask

  task automatic t_seek();
    logic [1:0] s;
    cmd_busy = 1; rw_active = 0;
    s = unit_sel; wait_clks(DWELL + 2);
    check("R7 polls during non-data command", int'(unit_sel != s), 1);
    cmd_busy = 0; rw_active = 1;
    s = unit_sel; wait_clks(DWELL + 2);
    check("R7 polls with rw_active alone", int'(unit_sel != s), 1);
    rw_active = 0;
  endtask

  task automatic t_same_drive();
    drv_rdy[0] = 0;
    wait_clks(SWEEP);
    check("R11 drive 0 pending", pend_drive, 0);
    check("R11 first not-ready", pend_not_ready, 1);
    drv_rdy[0] = 1;
    wait_clks(SWEEP);
    check("R11 still pending", int_o, 1);
    check("R11 bit follows newest sample", pend_not_ready, 0);
    ack();
    check("R11 single entry cleared", int_o, 0);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_no_change();
    t_multi();
    t_pause();
    t_seek();
    t_same_drive();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_clks(150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule